// File: doc/BRIEF.md
# Accumulating Correlation Detector Array

The block emulates, in adders and registers, a memory cell that accumulates each time it is written, and uses an array of such cells to find event streams that fire together. Each clock with `step_valid` high delivers one step: a vector with one event bit per channel. The block counts the set bits of the step (the momentum) and turns that count into an 8-bit increment. Every channel whose own bit is 1 adds this increment to its 16-bit accumulator; every other channel holds. Channels tied to streams that fire together see larger momenta whenever they fire, so their accumulators grow faster than those of independent streams.

Each stream is served by a group of replica channels. At read-out, a replica group is summed and divided by its size with a shift, and the mean is compared against a programmable threshold to give a correlated flag. A scan command walks the streams in ascending order and presents one mean value and flag per cycle. A clear command empties every accumulator so that a new detection window can start.

The controller has three states. ST_RUN accepts steps and commands. ST_RUN goes to ST_CLEAR on `clear_cmd`, else to ST_SCAN on `scan_cmd`, else stays. ST_CLEAR zeroes all accumulators and returns to ST_RUN after one cycle. ST_SCAN emits one stream per cycle and returns to ST_RUN after the last stream.

Top module: `corr_detect_top`

## Requirements
- R1: A step accepted in ST_RUN adds the increment min(popcount(step_bits) x GAIN, 255) to every channel whose bit is 1. Channels whose bit is 0 keep their value. The new values are visible from the next clock edge.
- R2: When popcount x GAIN, after the 255 cap, is below FLOOR, the step adds nothing to any channel.
- R3: An accumulator that would pass 0xFFFF stops at 0xFFFF and does not wrap.
- R4: `clear_cmd` in ST_RUN sends the block to ST_CLEAR for exactly one cycle, with `busy` high. All accumulators are zero afterwards, and later steps accumulate from zero.
- R5: `scan_cmd` in ST_RUN starts a scan. From the second edge on, `rd_valid` is high for N_STREAMS consecutive cycles, with `rd_stream` going 0, 1, ... N_STREAMS-1. `busy` is high until the last stream has been presented, and `rd_valid` is low at all other times.
- R6: `rd_avg` for stream s is the sum of channels s*REP through s*REP+REP-1, shifted right by log2(REP). REP is 1, 2 or 4.
- R7: `rd_flag` is 1 only when `rd_avg` is strictly greater than the threshold register. The register is written by `thr_we`/`thr_value` and resets to 0.
- R8: Steps presented while `busy` is high change no accumulator.
- R9: After reset, every accumulator is 0, `busy` and `rd_valid` are 0, and the threshold is 0.
- R10: In ST_RUN, `clear_cmd` takes priority over `scan_cmd`, and either command blocks a step presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_valid | input | 1 | Step vector present this cycle |
| step_bits | input | N_STREAMS*REP | One event bit per channel |
| clear_cmd | input | 1 | Zero all accumulators |
| scan_cmd | input | 1 | Start a read-out scan |
| thr_we | input | 1 | Load the threshold register |
| thr_value | input | 16 | New threshold value |
| busy | output | 1 | Block is in ST_CLEAR or ST_SCAN |
| rd_valid | output | 1 | Read-out entry present |
| rd_stream | output | max(1,log2(N_STREAMS)) | Stream index of the entry |
| rd_avg | output | 16 | Replica mean of the stream |
| rd_flag | output | 1 | Mean above threshold |

## Verification
The bench builds the block with four streams of two replicas each, a gain of 40 and a floor of 100. With these values, a popcount of 1 or 2 falls under the floor and a popcount of 7 or 8 reaches the 8-bit cap, so R2 and the increment cap are both reachable with an eight-bit step vector. Because 255 is the largest increment, about 260 all-ones steps are enough to drive every accumulator into its 0xFFFF ceiling. The two-replica groups make the averaging shift non-trivial, since the bench gives the replicas of one stream different bit patterns.

// File: rtl/corr_detect_pkg.sv
package corr_detect_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CLEAR = 2'd1,
        ST_SCAN  = 2'd2
    } corr_state_e;
endpackage

// File: rtl/corr_momentum.sv
module corr_momentum #(
    parameter int N_CH  = 8,
    parameter int INC_W = 8,
    parameter int GAIN  = 8,
    parameter int FLOOR = 16
) (
    input  logic [N_CH-1:0]  bits,
    output logic [INC_W-1:0] inc
);
    localparam int CNT_W   = $clog2(N_CH + 1);
    localparam int INC_MAX = (1 << INC_W) - 1;

    logic [CNT_W-1:0] pop;
    logic [31:0]      scaled;
    logic [31:0]      capped;

    always_comb begin
        pop = '0;
        for (int i = 0; i < N_CH; i++) begin
            pop = pop + CNT_W'(bits[i]);
        end
        scaled = 32'(pop) * 32'(GAIN);
        capped = (scaled > 32'(INC_MAX)) ? 32'(INC_MAX) : scaled;
        inc    = (capped < 32'(FLOOR)) ? '0 : INC_W'(capped);
    end
endmodule

// File: rtl/corr_cell.sv
module corr_cell #(
    parameter int ACC_W = 16,
    parameter int INC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [INC_W-1:0] inc,
    output logic [ACC_W-1:0] acc
);
    logic [ACC_W:0] sum;

    always_comb begin
        sum = {1'b0, acc} + (ACC_W+1)'(inc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (add_en) begin
            acc <= sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/corr_group_avg.sv
module corr_group_avg #(
    parameter int ACC_W = 16,
    parameter int REP   = 2
) (
    input  logic [REP*ACC_W-1:0] grp,
    output logic [ACC_W-1:0]     avg
);
    localparam int SH    = $clog2(REP);
    localparam int SUM_W = ACC_W + SH;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = '0;
        for (int r = 0; r < REP; r++) begin
            sum = sum + SUM_W'(grp[r*ACC_W +: ACC_W]);
        end
        avg = ACC_W'(sum >> SH);
    end
endmodule

// File: rtl/corr_detect_top.sv
module corr_detect_top #(
    parameter int N_STREAMS = 4,
    parameter int REP       = 2,
    parameter int ACC_W     = 16,
    parameter int INC_W     = 8,
    parameter int GAIN      = 8,
    parameter int FLOOR     = 16,
    localparam int N_CH     = N_STREAMS * REP,
    localparam int SIDX_W   = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_valid,
    input  logic [N_CH-1:0]   step_bits,
    input  logic              clear_cmd,
    input  logic              scan_cmd,
    input  logic              thr_we,
    input  logic [ACC_W-1:0]  thr_value,
    output logic              busy,
    output logic              rd_valid,
    output logic [SIDX_W-1:0] rd_stream,
    output logic [ACC_W-1:0]  rd_avg,
    output logic              rd_flag
);
    import corr_detect_pkg::*;

    localparam logic [SIDX_W-1:0] LAST_IDX = SIDX_W'(N_STREAMS - 1);

    corr_state_e           state, state_nx;
    logic [SIDX_W-1:0]     scan_idx;
    logic [ACC_W-1:0]      thr_q;
    logic [INC_W-1:0]      inc;
    logic                  take_step;
    logic [N_CH*ACC_W-1:0] acc_flat;
    logic [ACC_W-1:0]      avg_arr [N_STREAMS];
    logic [ACC_W-1:0]      avg_sel;

    // increment derived from the population count of the step
    corr_momentum #(
        .N_CH (N_CH),
        .INC_W(INC_W),
        .GAIN (GAIN),
        .FLOOR(FLOOR)
    ) u_mom (
        .bits(step_bits),
        .inc (inc)
    );

    assign take_step = (state == ST_RUN) && step_valid && !clear_cmd && !scan_cmd;

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_cell
            corr_cell #(
                .ACC_W(ACC_W),
                .INC_W(INC_W)
            ) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (state == ST_CLEAR),
                .add_en(take_step && step_bits[c]),
                .inc   (inc),
                .acc   (acc_flat[c*ACC_W +: ACC_W])
            );
        end
        for (genvar s = 0; s < N_STREAMS; s++) begin : g_grp
            corr_group_avg #(
                .ACC_W(ACC_W),
                .REP  (REP)
            ) u_avg (
                .grp(acc_flat[s*REP*ACC_W +: REP*ACC_W]),
                .avg(avg_arr[s])
            );
        end
    endgenerate

    always_comb begin
        avg_sel = avg_arr[0];
        for (int s = 0; s < N_STREAMS; s++) begin
            if (scan_idx == SIDX_W'(s)) begin
                avg_sel = avg_arr[s];
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (clear_cmd) begin
                    state_nx = ST_CLEAR;
                end else if (scan_cmd) begin
                    state_nx = ST_SCAN;
                end
            end
            ST_CLEAR: state_nx = ST_RUN;
            ST_SCAN: begin
                if (scan_idx == LAST_IDX) begin
                    state_nx = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and scan index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_stream <= '0;
            rd_avg    <= '0;
            rd_flag   <= 1'b0;
            scan_idx  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (state == ST_SCAN) begin
                rd_valid  <= 1'b1;
                rd_stream <= scan_idx;
                rd_avg    <= avg_sel;
                rd_flag   <= avg_sel > thr_q;
                scan_idx  <= (scan_idx == LAST_IDX) ? '0 : scan_idx + 1'b1;
            end else begin
                scan_idx <= '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q <= '0;
        end else if (thr_we) begin
            thr_q <= thr_value;
        end
    end

    assign busy = (state != ST_RUN);
endmodule

// File: rtl/corr_detect_checker.sv
module corr_detect_checker #(
    parameter int N_CH   = 8,
    parameter int ACC_W  = 16,
    parameter int SIDX_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [1:0]            state,
    input logic [N_CH*ACC_W-1:0] acc_flat,
    input logic                  rd_valid,
    input logic [SIDX_W-1:0]     rd_stream,
    input logic [ACC_W-1:0]      rd_avg,
    input logic                  rd_flag,
    input logic [ACC_W-1:0]      thr_q
);
    import corr_detect_pkg::*;

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_chk
            // accumulators never shrink except through a clear: no wrap
            assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(state) != 2'(ST_CLEAR)) |->
                (acc_flat[c*ACC_W +: ACC_W] >= $past(acc_flat[c*ACC_W +: ACC_W])));
            // nothing moves while the scan runs
            assert_pause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(state) == 2'(ST_SCAN)) |->
                (acc_flat[c*ACC_W +: ACC_W] == $past(acc_flat[c*ACC_W +: ACC_W])));
        end
    endgenerate

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == 2'(ST_CLEAR)) |-> (acc_flat == '0));

    assert_clear_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(ST_CLEAR)) |=> (state == 2'(ST_RUN)));

    assert_valid_from_scan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(state) == 2'(ST_SCAN)));

    assert_scan_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid)) |-> (rd_stream == SIDX_W'($past(rd_stream) + 1'b1)));

    assert_strict_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $stable(thr_q)) |-> (rd_flag == (rd_avg > thr_q)));
endmodule

bind corr_detect_top corr_detect_checker #(
    .N_CH  (N_CH),
    .ACC_W (ACC_W),
    .SIDX_W(SIDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .acc_flat (acc_flat),
    .rd_valid (rd_valid),
    .rd_stream(rd_stream),
    .rd_avg   (rd_avg),
    .rd_flag  (rd_flag),
    .thr_q    (thr_q)
);

// File: tb/tb_corr_detect_top.sv
`timescale 1ns/1ps
module tb_corr_detect_top;
    localparam int NS    = 4;
    localparam int REP   = 2;
    localparam int NCH   = NS * REP;
    localparam int GAIN  = 40;
    localparam int FLOOR = 100;
    localparam int SW    = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step_valid = 1'b0;
    logic [NCH-1:0]  step_bits = '0;
    logic            clear_cmd = 1'b0;
    logic            scan_cmd = 1'b0;
    logic            thr_we = 1'b0;
    logic [15:0]     thr_value = '0;
    logic            busy;
    logic            rd_valid;
    logic [SW-1:0]   rd_stream;
    logic [15:0]     rd_avg;
    logic            rd_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int model [NCH];
    int m_thr = 0;

    always #10 clk = ~clk;

    corr_detect_top #(
        .N_STREAMS(NS), .REP(REP), .ACC_W(16), .INC_W(8), .GAIN(GAIN), .FLOOR(FLOOR)
    ) dut (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_bits(step_bits),
        .clear_cmd(clear_cmd), .scan_cmd(scan_cmd), .thr_we(thr_we), .thr_value(thr_value),
        .busy(busy), .rd_valid(rd_valid), .rd_stream(rd_stream), .rd_avg(rd_avg),
        .rd_flag(rd_flag)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int incr_of(logic [NCH-1:0] b);
        int p = $countones(b);
        int v = p * GAIN;
        if (v > 255) v = 255;
        if (v < FLOOR) v = 0;
        return v;
    endfunction

    function automatic int exp_avg(int s);
        int sum = 0;
        for (int r = 0; r < REP; r++) sum += model[s*REP + r];
        return sum >> $clog2(REP);
    endfunction

    // one accepted step (R1, R2, R3 in the model)
    task automatic do_step(logic [NCH-1:0] b);
        int v = incr_of(b);
        @(negedge clk);
        step_valid = 1'b1;
        step_bits  = b;
        @(negedge clk);
        step_valid = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (b[c]) begin
                model[c] += v;
                if (model[c] > 65535) model[c] = 65535;
            end
        end
    endtask

    task automatic set_thr(int v);
        @(negedge clk);
        thr_we = 1'b1;
        thr_value = 16'(v);
        @(negedge clk);
        thr_we = 1'b0;
        m_thr = v;
    endtask

    // clear, optionally with a competing step and scan (R4, R10)
    task automatic do_clear(bit with_step, bit with_scan);
        @(negedge clk);
        clear_cmd = 1'b1;
        scan_cmd = with_scan;
        step_valid = with_step;
        step_bits = '1;
        @(negedge clk);
        clear_cmd = 1'b0;
        scan_cmd = 1'b0;
        step_valid = 1'b0;
        check("R4 busy in clear", int'(busy), 1);
        @(negedge clk);
        check("R4 clear lasts one cycle", int'(busy), 0);
        check("R10 scan loses to clear", int'(rd_valid), 0);
        for (int c = 0; c < NCH; c++) model[c] = 0;
    endtask

    // scan all streams, optionally pushing steps that must be ignored (R5-R8, R10)
    task automatic do_scan(bit poke, string tag);
        @(negedge clk);
        scan_cmd = 1'b1;
        step_valid = poke;
        step_bits = '1;
        @(negedge clk);
        scan_cmd = 1'b0;
        check({"R5 busy at scan start ", tag}, int'(busy), 1);
        check({"R5 no entry yet ", tag}, int'(rd_valid), 0);
        for (int s = 0; s < NS; s++) begin
            @(negedge clk);
            check({"R5 valid ", tag}, int'(rd_valid), 1);
            check({"R5 stream order ", tag}, int'(rd_stream), s);
            check({"R6 average ", tag}, int'(rd_avg), exp_avg(s));
            check({"R7 flag ", tag}, int'(rd_flag), int'(exp_avg(s) > m_thr));
        end
        step_valid = 1'b0;
        check({"R5 busy drops ", tag}, int'(busy), 0);
        @(negedge clk);
        check({"R5 valid drops ", tag}, int'(rd_valid), 0);
    endtask

    task automatic t_reset();
        check("R9 busy after reset", int'(busy), 0);
        check("R9 rd_valid after reset", int'(rd_valid), 0);
        do_scan(1'b0, "R9 reset");
    endtask

    task automatic t_basic();
        do_step(8'b0000_0111);   // pop 3 -> 120, stream1 one replica only
        do_step(8'b0111_1111);   // pop 7 -> capped 255
        do_step(8'b1000_0001);   // pop 2 -> 80 below floor: R2
        do_step(8'b0011_0000);   // pop 2 -> nothing: R2
        do_scan(1'b0, "R1 basic");
    endtask

    task automatic t_threshold();
        set_thr(exp_avg(0));
        do_scan(1'b0, "R7 equal");
        set_thr(exp_avg(0) - 1);
        do_scan(1'b0, "R7 below");
    endtask

    task automatic t_pause();
        do_scan(1'b1, "R8 steps during scan");
    endtask

    task automatic t_clear();
        do_clear(1'b1, 1'b1);
        do_scan(1'b0, "R4 zeroed R10");
        do_step(8'b1100_0011);   // pop 4 -> 160 from zero
        do_scan(1'b0, "R4 restart");
    endtask

    task automatic t_saturate();
        do_clear(1'b0, 1'b0);
        for (int k = 0; k < 260; k++) do_step('1);
        check("R3 model ceiling", model[0], 65535);
        do_scan(1'b0, "R3 saturate");
    endtask

    task automatic t_correlated();
        do_clear(1'b0, 1'b0);
        set_thr(2000);
        for (int k = 0; k < 40; k++) begin
            logic [NCH-1:0] b = '0;
            if (k % 3 != 2) b[3:0] = (k % 2 == 0) ? 4'b1111 : 4'b0111;
            if (k % 5 == 0) b[5:4] = 2'b01;
            if (k % 7 == 1) b[7:6] = 2'b11;
            do_step(b);
        end
        do_scan(1'b0, "R7 correlated groups");
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) model[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_threshold();
        t_pause();
        t_clear();
        t_saturate();
        t_correlated();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule